// File: doc/BRIEF.md
# Decade Divider Counter with Selectable Chaining

This block is a 4-bit decade counter made of two sections with separate count inputs. One is a divide-by-2 stage whose output is bit 0. The other is a divide-by-5 stage whose outputs are bits 3..1. Each section advances when its count input falls. Both count inputs are asynchronous to the block and are brought into the system clock domain before any edge is detected.

A 2-bit mode input sets how the sections are chained. In BCD mode the falling edge of bit 0 steps the divide-by-5 stage, so the outputs count 0 to 9 in binary. In bi-quinary mode the falling edge of bit 3 steps the divide-by-2 stage. Bit 0 then becomes a square-wave decade output. In external mode the sections are not chained, so each one can serve as a divide-by-2 tap or a divide-by-5 tap. An active-high asynchronous reset clears all four outputs. Two instances that share a reset can be cascaded to divide by 100.

Top module: `decade_divider`

## Requirements
- R1: In external mode, every falling edge on `cnt_a` toggles `q[0]`. The toggle appears on the third rising clock edge after the fall.
- R2: Every step of the divide-by-5 stage moves `q[3:1]` through 0, 1, 2, 3, 4 and back to 0, with `q[1]` as the least significant bit. In external mode a falling edge on `cnt_b` gives one step.
- R3: In BCD mode (`mode` = 2'b00) the count enters on `cnt_a`, and a falling `q[0]` steps the divide-by-5 stage. `q[3:0]` counts 0 to 9 in binary and then wraps to 0. The carry settles within two clocks after `q[0]` changes.
- R4: In bi-quinary mode (`mode` = 2'b01) the count enters on `cnt_b`, and a falling `q[3]` toggles `q[0]`. For counts 0–4, `q[0]` is 0 and `q[3:1]` equals the count. For counts 5–9, `q[0]` is 1 and `q[3:1]` equals the count minus 5. This makes `q[0]` a 50% duty output at one tenth of the input rate.
- R5: In BCD mode, `cnt_b` has no effect on the outputs. In bi-quinary mode, `cnt_a` has no effect on the outputs.
- R6: While `rst` is high, `q` is 4'b0000 immediately, without waiting for a clock, whatever the count inputs do.
- R7: A count input that is high while reset is asserted or released produces no count. Its first fall after reset is counted normally.
- R8: `mode` values 2'b10 and 2'b11 both select external mode, in which neither section is chained to the other.
- R9: Two instances can be cascaded with the first instance's `q[3]` driving the second instance's `cnt_a`, both in BCD mode. This pair holds units and tens of a count of input pulses and returns to 00 after 100 pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both count inputs are sampled on it |
| rst | input | 1 | Asynchronous master reset, active high |
| mode | input | 2 | 00 BCD, 01 bi-quinary, 10/11 external |
| cnt_a | input | 1 | Count input of the divide-by-2 section |
| cnt_b | input | 1 | Count input of the divide-by-5 section |
| q | output | 4 | Counter outputs: q[0] from divide-by-2, q[3:1] from divide-by-5 |

## Verification
A fall on a count input reaches `q[0]` or `q[3:1]` on the third rising edge after it. The carry of a chained section lands one edge later, on the fourth. A cascaded second instance sees its `cnt_a` fall on that fourth edge and updates three edges after that, at the seventh, with its own carry at the eighth. Every bench pulse therefore holds each level for ten clocks, and outputs are sampled on falling clock edges after the full pulse, so the latest of these results has settled. The reset result is due with no clock at all, so it is sampled one nanosecond after `rst` rises.

// File: rtl/decade_divider.sv
module decade_divider #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       cnt_a,
  input  logic       cnt_b,
  output logic [3:0] q
);
  localparam logic [1:0] MODE_BCD = 2'b00;
  localparam logic [1:0] MODE_BIQ = 2'b01;
  localparam int         PREV     = SYNC_STAGES;

  logic [SYNC_STAGES:0] sync_a, sync_b;
  logic                 armed, q0_prev, q3_prev;
  logic                 bit0;
  logic [2:0]           quin;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      sync_a <= '0;
      sync_b <= '0;
      armed  <= 1'b0;
    end else begin
      sync_a <= {sync_a[SYNC_STAGES-1:0], cnt_a};
      sync_b <= {sync_b[SYNC_STAGES-1:0], cnt_b};
      armed  <= 1'b1;
    end

  wire fall_a  = sync_a[PREV] & ~sync_a[PREV-1];
  wire fall_b  = sync_b[PREV] & ~sync_b[PREV-1];
  wire q0_fall = q0_prev & ~bit0;
  wire q3_fall = q3_prev & ~quin[2];

  wire step_a = armed & ((mode == MODE_BIQ) ? q3_fall : fall_a);
  wire step_b = armed & ((mode == MODE_BCD) ? q0_fall : fall_b);

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      bit0    <= 1'b0;
      quin    <= 3'd0;
      q0_prev <= 1'b0;
      q3_prev <= 1'b0;
    end else begin
      q0_prev <= bit0;
      q3_prev <= quin[2];
      if (step_a) bit0 <= ~bit0;
      if (step_b) quin <= (quin == 3'd4) ? 3'd0 : quin + 3'd1;
    end

  assign q = {quin, bit0};

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |-> q == 4'd0); // R6

  AST_QUIN_SEQUENCE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(q[3:1])) |->
      q[3:1] == (($past(q[3:1]) == 3'd4) ? 3'd0 : $past(q[3:1]) + 3'd1)); // R2

  AST_BCD_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(mode) == MODE_BCD && !$stable(q[3:1])) |->
      ($past(q[0], 2) && !$past(q[0]))); // R3

  AST_BIQ_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(mode) == MODE_BIQ && !$stable(q[0])) |->
      ($past(q[3], 2) && !$past(q[3]))); // R4

  AST_EXT_Q0_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode[1]) && !$stable(q[0])) |-> !$past(q3_fall) || $past(fall_a)); // R8
endmodule

// File: tb/tb_decade_divider.sv
module tb_decade_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       cnt_a = 1'b0, cnt_b = 1'b0;
  logic [3:0] q, q_hi;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  decade_divider dut (.clk(clk), .rst(rst), .mode(mode), .cnt_a(cnt_a), .cnt_b(cnt_b), .q(q));
  decade_divider dut_hi (.clk(clk), .rst(rst), .mode(2'b00), .cnt_a(q[3]), .cnt_b(1'b0), .q(q_hi));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input bit on_a);
    @(negedge clk);
    if (on_a) cnt_a = 1'b1; else cnt_b = 1'b1;
    repeat (10) @(negedge clk);
    if (on_a) cnt_a = 1'b0; else cnt_b = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; mode = m;
    repeat (3) @(negedge clk);
    chk("R6 reset state", q, 4'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [3:0] biq(input int k);
    return {3'(k % 5), (k >= 5) ? 1'b1 : 1'b0};
  endfunction

  task automatic test_bcd;
    do_reset(2'b00);
    for (int n = 1; n <= 100; n++) begin
      pulse(1'b1);
      chk("R3 bcd count", q, 4'(n % 10));
    end
    pulse(1'b0);
    chk("R5 bcd ignores cnt_b", q, 4'd0);
  endtask

  task automatic test_biq;
    do_reset(2'b01);
    for (int n = 1; n <= 100; n++) begin
      pulse(1'b0);
      chk("R4 biquinary count", q, biq(n % 10));
      if (n == 7) begin
        pulse(1'b1);
        chk("R5 biquinary ignores cnt_a", q, biq(7));
      end
    end
  endtask

  task automatic test_ext(input logic [1:0] m);
    int na = 0, nb = 0;
    do_reset(m);
    for (int n = 0; n < 100; n++) begin
      if (n % 3 == 0) begin pulse(1'b0); nb++; end
      else begin pulse(1'b1); na++; end
      chk("R1 R2 R8 external taps", q, {3'(nb % 5), 1'(na % 2)});
    end
  endtask

  task automatic test_reset_mid;
    do_reset(2'b00);
    repeat (7) pulse(1'b1);
    chk("R3 before reset", q, 4'd7);
    @(negedge clk);
    rst = 1'b1;
    #1;
    chk("R6 async clear", q, 4'd0);
    cnt_a = 1'b1;
    repeat (3) @(negedge clk);
    cnt_a = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 reset overrides count", q, 4'd0);
    rst = 1'b0;
    repeat (3) pulse(1'b1);
    chk("R6 count after reset", q, 4'd3);
  endtask

  task automatic test_high_at_release;
    @(negedge clk);
    rst = 1'b1; mode = 2'b10; cnt_a = 1'b1; cnt_b = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    chk("R7 no count at release", q, 4'd0);
    cnt_a = 1'b0; cnt_b = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 first fall counted", q, 4'b0011);
  endtask

  task automatic test_cascade;
    do_reset(2'b00);
    for (int n = 1; n <= 100; n++) begin
      pulse(1'b1);
      chk("R9 units", q, 4'(n % 10));
      chk("R9 tens", q_hi, 4'((n / 10) % 10));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 initial reset", q, 4'd0);
    test_bcd();
    test_biq();
    test_ext(2'b10);
    test_ext(2'b11);
    test_reset_mid();
    test_high_at_release();
    test_cascade();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule